// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous, idle-high serial line into parallel bytes. A free-running tick generator, set by a programmable divisor, produces a strobe at sixteen times the bit rate. When the line falls, the receiver waits half a bit (eight ticks) and looks again. If the line is still low, the start bit is accepted. Otherwise the event is treated as noise and dropped.

Once a start bit is accepted, the receiver takes one sample every sixteen ticks, so that each sample lands at the middle of a data bit. The bits are shifted into a staging register, least significant bit first. A frame whose stop bit reads high copies the byte into the output register, which can drive LEDs or any other parallel load, and sets a buffer-full flag. A frame whose stop bit reads low leaves the output untouched and raises a one-cycle error pulse. The full flag clears when the consumer pulses a read acknowledge.

Top module: `serial_byte_receiver`

## Requirements
- R1: The expected frame is a low start bit, then 8 data bits, then a high stop bit. The first data bit received ends up in `rx_data[0]` and the last in `rx_data[7]`.
- R2: The oversampling tick fires once every `divisor`+1 clock cycles, and one bit time is 16 ticks. A divisor of 0 gives one tick per clock.
- R3: After a falling edge on the synchronized line, the line is checked again on the 8th tick. If it is high there, the receiver returns to idle and produces no byte, no flag change and no error.
- R4: After the start bit is confirmed, each data bit and then the stop bit are sampled every 16 ticks. A sender whose bit time is off by about 3 % is still received correctly.
- R5: The serial input passes through two flip-flops before edge detection, so the receiver sees a change on `rxd_in` two clocks after it happens.
- R6: When the stop bit samples low, `frame_err` goes high, and `rx_data` and `rx_full` keep their previous values.
- R7: A frame that ends with a high stop bit updates `rx_data` and sets `rx_full` one clock after the stop sample. `rx_full` stays set until `rd_ack` is high at a clock edge. If a new byte lands in the same cycle as `rd_ack`, the set wins.
- R8: After reset, `rx_data` is 0, `rx_full` is 0, `frame_err` is 0 and the line is treated as idle.
- R9: `frame_err` is high for exactly one clock per bad frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset. The block releases it internally in step with `clk`. |
| divisor | input | DIV_W | Clocks per oversampling tick, minus one |
| rxd_in | input | 1 | Asynchronous serial line, high when idle |
| rd_ack | input | 1 | Consumer has taken the byte; clears `rx_full` |
| rx_data | output | DATA_W | Last byte received with a valid stop bit |
| rx_full | output | 1 | A received byte is waiting to be read |
| frame_err | output | 1 | One-cycle pulse when a stop bit samples low |

## Verification
A change on `rxd_in` reaches the edge detector two clocks later. The start decision falls on the eighth tick after that edge, and the stop-bit decision falls 144 ticks after the start decision. `frame_err` rises on the clock edge of the stop decision, while `rx_data` and `rx_full` change one clock later. `rd_ack` clears the flag on the next edge. A behavioural reference model, stepped on each rising edge with those same latencies, is compared against the outputs at every falling edge. The directed checks then read the ports only after the whole stop bit plus eight further clocks have passed, when every result from the frame is final.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_reset_sync.sv
module srx_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic r1_q, r2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_n_o = r2_q;
endmodule

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_n;
  logic              prev_q, prev_n;

  // next state: shift the raw line through the chain, remember the last output
  always_comb begin
    chain_n = {chain_q[STAGES-2:0], din};
    prev_n  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_n;
      prev_q  <= prev_n;
    end
  end

  assign dout = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = (cnt_q >= divisor);
    cnt_n = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              fall,
  output logic [DATA_W-1:0] shreg,
  output logic              frame_ok,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] BIT_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  tc_q, tc_n;
  logic [IDX_W-1:0]  bi_q, bi_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              ok_q, ok_n, er_q, er_n;

  always_comb begin
    st_n = st_q;
    tc_n = tc_q;
    bi_n = bi_q;
    sh_n = sh_q;
    ok_n = 1'b0;
    er_n = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (fall) begin
          st_n = RX_START;
          tc_n = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (tc_q == HALF_LAST) begin
            if (!line) begin
              st_n = RX_DATA;
              tc_n = '0;
              bi_n = '0;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            tc_n = tc_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (tc_q == FULL_LAST) begin
            sh_n = {line, sh_q[DATA_W-1:1]};
            tc_n = '0;
            if (bi_q == BIT_LAST) st_n = RX_STOP;
            else                  bi_n = bi_q + 1'b1;
          end else begin
            tc_n = tc_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (tc_q == FULL_LAST) begin
            ok_n = line;
            er_n = ~line;
            st_n = RX_IDLE;
          end else begin
            tc_n = tc_q + 1'b1;
          end
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE;
      tc_q <= '0;
      bi_q <= '0;
      sh_q <= '0;
      ok_q <= 1'b0;
      er_q <= 1'b0;
    end else begin
      st_q <= st_n;
      tc_q <= tc_n;
      bi_q <= bi_n;
      sh_q <= sh_n;
      ok_q <= ok_n;
      er_q <= er_n;
    end
  end

  assign shreg     = sh_q;
  assign frame_ok  = ok_q;
  assign frame_err = er_q;
endmodule

// File: rtl/serial_byte_receiver.sv
module serial_byte_receiver #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              rxd_in,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              frame_err
);
  logic              rst_int_n;
  logic              line_s, line_fall, tick;
  logic [DATA_W-1:0] shreg;
  logic              frame_ok;
  logic [DATA_W-1:0] data_q, data_n;
  logic              full_q, full_n;

  srx_reset_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  srx_line_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (rxd_in),
    .dout  (line_s),
    .fall  (line_fall)
  );

  srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .divisor (divisor),
    .tick    (tick)
  );

  srx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .line      (line_s),
    .fall      (line_fall),
    .shreg     (shreg),
    .frame_ok  (frame_ok),
    .frame_err (frame_err)
  );

  // holding register and full flag: a new byte wins over a read acknowledge
  always_comb begin
    data_n = data_q;
    full_n = full_q;
    if (frame_ok) begin
      data_n = shreg;
      full_n = 1'b1;
    end else if (rd_ack) begin
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      data_q <= data_n;
      full_q <= full_n;
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ack,
  input logic              load,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              frame_err
);
  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_ack) |=> rx_full);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !load) |=> !rx_full);

  // R6
  data_moves_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);

  // R6
  bad_stop_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(rx_data));

  // R9
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
endmodule

bind serial_byte_receiver srx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_ack    (rd_ack),
  .load      (frame_ok),
  .rx_data   (rx_data),
  .rx_full   (rx_full),
  .frame_err (frame_err)
);

// File: tb/sim_serial_byte_receiver.sv
`timescale 1ns/1ps
module sim_serial_byte_receiver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] divisor;
  logic        rxd;
  logic        rd_ack;
  logic [7:0]  rx_data;
  logic        rx_full;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int err_pulses = 0;
  int full_cycles = 0;
  bit started = 0;

  always #10 clk = ~clk;

  serial_byte_receiver u0 (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .rxd_in(rxd),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err)
  );

  // behavioural reference model, stepped on every rising edge
  int m_rs1 = 0, m_rs2 = 0, m_cnt = 0, m_st = 0, m_tc = 0, m_bi = 0;
  int m_s1 = 1, m_s2 = 1, m_prev = 1;
  logic [7:0] m_sh = 0, m_data = 0;
  bit m_full = 0, m_ld = 0, m_err = 0;

  task automatic model_reset();
    m_cnt = 0; m_st = 0; m_tc = 0; m_bi = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
    m_sh = 0; m_data = 0; m_full = 0; m_ld = 0; m_err = 0;
  endtask

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_reset();
    end else begin
      int old_rs;
      bit tk, fl;
      old_rs = m_rs2; m_rs2 = m_rs1; m_rs1 = 1;
      if (old_rs == 0) model_reset();
      else begin
        if (m_ld) begin m_data = m_sh; m_full = 1; end
        else if (rd_ack) m_full = 0;
        m_ld = 0; m_err = 0;
        tk = (m_cnt >= int'(divisor));
        m_cnt = tk ? 0 : m_cnt + 1;
        fl = (m_prev == 1) && (m_s2 == 0);
        if (m_st == 0) begin
          if (fl) begin m_st = 1; m_tc = 0; end
        end else if (tk) begin
          if (m_st == 1) begin
            if (m_tc == 7) begin
              if (m_s2 == 0) begin m_st = 2; m_tc = 0; m_bi = 0; end
              else m_st = 0;
            end else m_tc++;
          end else if (m_st == 2) begin
            if (m_tc == 15) begin
              m_sh = {m_s2[0], m_sh[7:1]};
              m_tc = 0;
              if (m_bi == 7) m_st = 3; else m_bi++;
            end else m_tc++;
          end else begin
            if (m_tc == 15) begin
              if (m_s2 == 1) m_ld = 1; else m_err = 1;
              m_st = 0;
            end else m_tc++;
          end
        end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
      end
    end
    if (frame_err) err_pulses++;
    if (rx_full) full_cycles++;
    cycles++;
  end

  // every-clock comparison with the model, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rx_data !== m_data) begin
        errors++;
        $display("FAIL R4/R5 model rx_data actual=%h expected=%h t=%0t", rx_data, m_data, $time);
      end
      checks++;
      if (rx_full !== m_full) begin
        errors++;
        $display("FAIL R7 model rx_full actual=%b expected=%b t=%0t", rx_full, m_full, $time);
      end
      checks++;
      if (frame_err !== m_err) begin
        errors++;
        $display("FAIL R6 model frame_err actual=%b expected=%b t=%0t", frame_err, m_err, $time);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(int div);
    @(negedge clk);
    rst_n = 0; divisor = 16'(div);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, logic stop_val, int bit_clks);
    rxd = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    rxd = stop_val;
    repeat (bit_clks) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic int bt();
    return 16 * (int'(divisor) + 1);
  endfunction

  initial begin
    rst_n = 0; divisor = 16'd3; rxd = 1'b1; rd_ack = 1'b0;
    do_reset(3);
    // R8 reset state
    check("R8 rx_data after reset", rx_data, 0);
    check("R8 rx_full after reset", rx_full, 0);
    check("R8 frame_err after reset", frame_err, 0);

    // R1 basic frame, LSB first
    send(8'hA5, 1'b1, bt());
    check("R1 byte A5", rx_data, 8'hA5);
    check("R7 full set", rx_full, 1);

    // R7 second byte without acknowledge
    send(8'h3C, 1'b1, bt());
    check("R1 byte 3C", rx_data, 8'h3C);
    check("R7 full still set", rx_full, 1);

    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
    check("R7 full cleared by rd_ack", rx_full, 0);
    check("R7 data kept after rd_ack", rx_data, 8'h3C);

    // R3 short glitch rejected
    err_pulses = 0;
    rxd = 1'b0; repeat (20) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    check("R3 glitch no full", rx_full, 0);
    check("R3 glitch data kept", rx_data, 8'h3C);
    check("R3 glitch no error", err_pulses, 0);

    // R6 / R9 bad stop bit
    err_pulses = 0;
    send(8'h81, 1'b0, bt());
    check("R6 bad stop data kept", rx_data, 8'h3C);
    check("R6 bad stop full clear", rx_full, 0);
    check("R9 one error pulse", err_pulses, 1);

    // R4 sender slightly fast (62 clocks per bit instead of 64)
    send(8'h6B, 1'b1, bt() - 2);
    check("R4 skewed sender", rx_data, 8'h6B);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);

    // R7 set wins over a held acknowledge
    full_cycles = 0;
    rd_ack = 1'b1;
    send(8'h96, 1'b1, bt());
    rd_ack = 1'b0;
    check("R7 data with ack held", rx_data, 8'h96);
    check("R7 full one cycle under ack", full_cycles, 1);
    check("R7 full cleared under ack", rx_full, 0);

    // R2 divisor settings
    do_reset(0);
    send(8'h5A, 1'b1, bt());
    check("R2 divisor 0 byte", rx_data, 8'h5A);
    do_reset(7);
    send(8'hC3, 1'b1, bt());
    check("R2 divisor 7 byte", rx_data, 8'hC3);
    // R5 timing is covered by the model comparison (two-clock line delay)
    check("R5 full after divisor 7 frame", rx_full, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule